// File: doc/BRIEF.md
# Byte-wide SPI master/slave controller

This block is a full-duplex serial peripheral interface for a small register bus. One shift register of `BITS` bits sends a byte on MOSI while it takes in a byte on MISO. A control bit selects the role. As master, the block generates the serial clock from the system clock with one of four division ratios, and a write to the data register starts the transfer. As slave, it follows an external serial clock while its active-low select input is low. When a byte completes, the received value is copied into a separate read buffer, so software can read it while the next byte shifts. The completion flag raises the interrupt request.

Software sees three registers. Address 0 is control, address 1 is status and address 2 is data. All four clock polarity/phase modes are supported, and either bit order. A write to the data register during a transfer is refused and flagged as a write collision. While the block is master and its select input is honoured, another master pulling that input low forces the block back to slave.

Top module: `sercom_spi`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x00, `irq`, `pin_en` and every output enable are low.
- R2: Control bits [1:0] pick the master serial-clock half period: 2, 8, 32 or 64 system cycles for codes 0..3, that is, the system clock divided by 4, 16, 64 or 128. The complete flag becomes visible 17 half periods after the clock edge that accepts the data write.
- R3: A master/slave pair exchanges full bytes in both directions at once. Each side's received byte can be read at address 2 and stays unchanged until the next completion.
- R4: Control bit 5 selects the bit order: 0 sends the most significant bit first, 1 sends the least significant bit first.
- R5: Control bit 3 (polarity) sets the idle level of the serial clock. Control bit 2 (phase) set to 0 samples on the leading edge; set to 1 it samples on the trailing edge. All four combinations exchange bytes correctly.
- R6: Status bit 7 is set when a byte completes, and `irq` is high exactly while it is set.
- R7: A data write while status bit 0 (busy) is high sets status bit 6 and leaves the byte in flight unchanged.
- R8: Writing 1 to status bit 7 or bit 6 clears that flag. Writing 0 has no effect.
- R9: With control bit 6 (enable) at 0, `pin_en` and all output enables are low, and a data write starts nothing.
- R10: A slave whose select input is high leaves MISO undriven and ignores the serial clock. It neither completes a byte nor changes its read buffer.
- R11: With control bit 7 at 0, a master whose select input is low clears its master bit (control bit 4). With control bit 7 at 1, the select input is ignored in master mode.
- R12: Status bit 0 reads 1 while a transfer is in progress and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | BITS | Register write data |
| bus_rdata | output | BITS | Register read data (combinational) |
| irq | output | 1 | Interrupt request, follows the complete flag |
| pin_en | output | 1 | Pins owned by the serial port when high |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-to-slave data in (slave) |
| mosi_o | output | 1 | Master-to-slave data out (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Slave-to-master data in (master) |
| miso_o | output | 1 | Slave-to-master data out (slave) |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The hardest case to reach from the ports is a data write that lands partway through a byte. Because the serial clock is internal, a write sent at an arbitrary time would usually arrive while the block is idle and simply start a new transfer. The bench therefore counts system cycles from the accepted start write and issues the colliding write at a known point inside the first half periods. It then checks that the flag is set and that both received bytes are intact. The ratio of four is the tightest case for the slave's synchronised clock path, and every mode and bit order is swept at that ratio as well.

// File: rtl/sercom_spi_pkg.sv
package sercom_spi_pkg;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int ST_DONE = 7;
  localparam int ST_WCOL = 6;
  localparam int ST_BUSY = 0;

  typedef struct packed {
    logic       ss_ign;
    logic       en;
    logic       lsb;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // half period of the master serial clock in system cycles
  function automatic int unsigned half_cycles(input logic [1:0] rate);
    case (rate)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/sercom_spi_sync.sv
module sercom_spi_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= din;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/sercom_spi_baud.sv
module sercom_spi_baud
  import sercom_spi_pkg::*;
#(
  parameter int MAX_HALF = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int CW = $clog2(MAX_HALF);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(half_cycles(rate) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R2: at least two cycles between serial clock edges
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sercom_spi_engine.sv
module sercom_spi_engine #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            master,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            lsb,
  input  logic            load,
  input  logic [BITS-1:0] wdata,
  input  logic            tick,
  input  logic            abort,
  input  logic            miso_i,
  input  logic            sck_s,
  input  logic            mosi_s,
  input  logic            sel_s,
  output logic            active,
  output logic            sck_o,
  output logic            mosi_o,
  output logic            miso_o,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] done_byte
);
  localparam int EW = $clog2(2 * BITS + 1);
  localparam int BW = $clog2(BITS);

  function automatic logic [BITS-1:0] shift_in(input logic [BITS-1:0] v,
                                               input logic b, input logic lsbf);
    return lsbf ? {b, v[BITS-1:1]} : {v[BITS-2:0], b};
  endfunction

  function automatic logic out_bit(input logic [BITS-1:0] v, input logic lsbf);
    return lsbf ? v[0] : v[BITS-1];
  endfunction

  logic [BITS-1:0] sr;
  logic [EW-1:0]   ecnt;
  logic [BW-1:0]   bcnt;
  logic            act, sck_r, samp, sck_q;

  // master sequencing events
  logic m_last, m_edge, m_samp, m_shift;
  assign m_last  = act && tick && (ecnt == EW'(2 * BITS));
  assign m_edge  = act && tick && !m_last;
  assign m_samp  = m_edge && (ecnt[0] == cpha);
  assign m_shift = m_edge && (ecnt[0] != cpha) && !(cpha && ecnt == '0);

  // slave sequencing events
  logic slave_on, sck_edge, s_lead, s_sample, s_last;
  assign slave_on = en && !master && sel_s;
  assign sck_edge = sck_s != sck_q;
  assign s_lead   = sck_s != cpol;
  assign s_sample = slave_on && sck_edge && (s_lead ^ cpha);
  assign s_last   = s_sample && (bcnt == BW'(BITS - 1));

  assign done      = m_last || s_last;
  assign done_byte = m_last ? (cpha ? shift_in(sr, samp, lsb) : sr)
                            : shift_in(sr, mosi_s, lsb);
  assign busy      = act || (bcnt != '0);
  assign active    = act;
  assign sck_o     = act ? sck_r : cpol;
  assign mosi_o    = out_bit(sr, lsb);
  assign miso_o    = out_bit(sr, lsb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      ecnt  <= '0;
      sck_r <= 1'b0;
      samp  <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      if (m_samp) samp <= miso_i;
      if (!en || abort) begin
        act <= 1'b0;
      end else if (load && master) begin
        act   <= 1'b1;
        ecnt  <= '0;
        sck_r <= cpol;
      end else if (m_last) begin
        act <= 1'b0;
      end else if (m_edge) begin
        sck_r <= ~sck_r;
        ecnt  <= ecnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sr <= '0;
    else if (load)               sr <= wdata;
    else if (m_shift)            sr <= shift_in(sr, samp, lsb);
    else if (m_last && cpha)     sr <= shift_in(sr, samp, lsb);
    else if (s_sample)           sr <= shift_in(sr, mosi_s, lsb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bcnt <= '0;
    else if (!slave_on)  bcnt <= '0;
    else if (s_sample)   bcnt <= s_last ? '0 : bcnt + 1'b1;
  end

  // R2: the serial clock moves only on a divider tick
  p_sck_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !tick) |=> $stable(sck_r));
  // R2: never more than two edges per bit
  p_edge_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (ecnt <= EW'(2 * BITS)));
  // R10: a deselected slave holds no partial byte
  p_desel_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> (bcnt == '0));
  // R9: disabling stops a master transfer
  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !act);
  // R6: the final tick ends the transfer
  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |=> !act);
endmodule

// File: rtl/sercom_spi.sv
module sercom_spi
  import sercom_spi_pkg::*;
#(
  parameter int BITS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [BITS-1:0] bus_wdata,
  output logic [BITS-1:0] bus_rdata,
  output logic            irq,
  output logic            pin_en,
  input  logic            sck_i,
  output logic            sck_o,
  output logic            sck_oe,
  input  logic            mosi_i,
  output logic            mosi_o,
  output logic            mosi_oe,
  input  logic            miso_i,
  output logic            miso_o,
  output logic            miso_oe,
  input  logic            ss_n_i
);
  ctrl_t           ctrl;
  logic            done_f, wcol_f;
  logic [BITS-1:0] rbuf;

  logic wr_ctrl, wr_stat, wr_data;
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_data = bus_wr && (bus_addr == A_DATA);

  logic ss_s, mosi_s, sck_s;
  sercom_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ss_n_i, mosi_i, sck_i}),
    .dout({ss_s, mosi_s, sck_s})
  );

  logic busy, active, done, tick, fault, load, wcol_evt;
  logic [BITS-1:0] done_byte;

  assign fault    = ctrl.en && ctrl.master && !ctrl.ss_ign && !ss_s;
  assign load     = wr_data && !busy;
  assign wcol_evt = wr_data && busy;

  sercom_spi_baud u_baud (
    .clk(clk), .rst_n(rst_n), .run(active), .rate(ctrl.rate), .tick(tick)
  );

  sercom_spi_engine #(.BITS(BITS)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl.en), .master(ctrl.master), .cpol(ctrl.cpol), .cpha(ctrl.cpha),
    .lsb(ctrl.lsb), .load(load), .wdata(bus_wdata), .tick(tick),
    .abort(fault), .miso_i(miso_i), .sck_s(sck_s), .mosi_s(mosi_s),
    .sel_s(!ss_s), .active(active), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_o(miso_o), .busy(busy), .done(done), .done_byte(done_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[7:0]);
      if (fault)   ctrl.master <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0;
      wcol_f <= 1'b0;
      rbuf   <= '0;
    end else begin
      done_f <= done || (done_f && !(wr_stat && bus_wdata[ST_DONE]));
      wcol_f <= wcol_evt || (wcol_f && !(wr_stat && bus_wdata[ST_WCOL]));
      if (done) rbuf <= done_byte;
    end
  end

  logic [7:0] stat;
  always_comb begin
    stat = '0;
    stat[ST_DONE] = done_f;
    stat[ST_WCOL] = wcol_f;
    stat[ST_BUSY] = busy;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = BITS'(ctrl);
      A_STAT:  bus_rdata = BITS'(stat);
      A_DATA:  bus_rdata = rbuf;
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = done_f;
  assign pin_en  = ctrl.en;
  assign sck_oe  = ctrl.en && ctrl.master;
  assign mosi_oe = ctrl.en && ctrl.master;
  assign miso_oe = ctrl.en && !ctrl.master && !ss_s;

  // R7: a refused write is always flagged
  p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |=> wcol_f);
  // R3: the read buffer changes only on completion
  p_rbuf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rbuf));
  // R11: a select conflict drops the master role
  p_fault_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !ctrl.master);
  // R6: completion raises the request
  p_done_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq);
endmodule

// File: tb/sercom_spi_test.sv
module sercom_spi_test;
  localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [1:0] m_addr = '0, s_addr = '0;
  logic       m_wr = 0, s_wr = 0;
  logic [7:0] m_wd = '0, s_wd = '0;
  logic [7:0] m_rd, s_rd;
  logic       m_ss = 1, s_ss = 1;
  logic m_irq, m_pen, m_sck, m_sck_oe, m_mosi, m_mosi_oe, m_miso, m_miso_oe;
  logic s_irq, s_pen, s_sck, s_sck_oe, s_mosi, s_mosi_oe, s_miso, s_miso_oe;
  logic miso_line;
  assign miso_line = s_miso_oe ? s_miso : 1'b1;

  sercom_spi uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(m_addr), .bus_wr(m_wr), .bus_wdata(m_wd),
    .bus_rdata(m_rd), .irq(m_irq), .pin_en(m_pen), .sck_i(1'b0), .sck_o(m_sck),
    .sck_oe(m_sck_oe), .mosi_i(1'b0), .mosi_o(m_mosi), .mosi_oe(m_mosi_oe),
    .miso_i(miso_line), .miso_o(m_miso), .miso_oe(m_miso_oe), .ss_n_i(m_ss)
  );

  sercom_spi peer (
    .clk(clk), .rst_n(rst_n), .bus_addr(s_addr), .bus_wr(s_wr), .bus_wdata(s_wd),
    .bus_rdata(s_rd), .irq(s_irq), .pin_en(s_pen), .sck_i(m_sck), .sck_o(s_sck),
    .sck_oe(s_sck_oe), .mosi_i(m_mosi), .mosi_o(s_mosi), .mosi_oe(s_mosi_oe),
    .miso_i(1'b1), .miso_o(s_miso), .miso_oe(s_miso_oe), .ss_n_i(s_ss)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input bit slv, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (slv) begin s_addr = a; s_wd = d; s_wr = 1; end
    else     begin m_addr = a; m_wd = d; m_wr = 1; end
    @(negedge clk);
    s_wr = 0; m_wr = 0;
  endtask

  task automatic br(input bit slv, input logic [1:0] a, output logic [7:0] d);
    if (slv) begin s_addr = a; #1; d = s_rd; end
    else     begin m_addr = a; #1; d = m_rd; end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  function automatic int half_of(input int r);
    return (r == 0) ? 2 : (r == 1) ? 8 : (r == 2) ? 32 : 64;
  endfunction

  task automatic xfer(input int rate, input int mode, input int lsb,
                      input logic [7:0] mb, input logic [7:0] sb);
    logic [7:0] cfg, cap, d;
    logic cpol, cpha, prev;
    int h;
    cpol = mode[1]; cpha = mode[0]; h = half_of(rate);
    cfg = 8'((lsb << 5) | (cpol << 3) | (cpha << 2) | rate);
    s_ss = 1;
    bw(0, AC, cfg | 8'h50);
    bw(1, AC, cfg | 8'h40);
    repeat (4) @(negedge clk);
    chk("R5 idle clock level", m_sck, cpol);
    bw(1, AD, sb);
    s_ss = 0;
    repeat (4) @(negedge clk);
    prev = m_sck; cap = '0;
    bw(0, AD, mb);
    for (int n = 1; n <= 17 * h; n++) begin
      @(negedge clk);
      if (m_sck != prev) begin
        if ((m_sck != cpol) ^ cpha) cap = {cap[6:0], m_mosi};
        prev = m_sck;
      end
      if (n == 17 * h - 1) chk("R2 flag not early", m_irq, 0);
    end
    chk("R2 R6 flag at 17 half periods", m_irq, 1);
    chk("R4 serial bit order", cap, lsb ? rev8(mb) : mb);
    repeat (4) @(negedge clk);
    br(0, AD, d); chk("R3 R5 master received", d, sb);
    br(1, AD, d); chk("R3 R5 slave received", d, mb);
    chk("R6 slave irq", s_irq, 1);
    bw(0, AS, 8'hC0);
    bw(1, AS, 8'hC0);
    s_ss = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    br(0, AC, d); chk("R1 ctrl reset", d, 0);
    br(0, AS, d); chk("R1 status reset", d, 0);
    chk("R1 irq reset", m_irq, 0);
    chk("R1 pin_en reset", m_pen, 0);
    chk("R1 enables reset", {m_sck_oe, m_mosi_oe, s_miso_oe}, 0);

    // R2 R3 R4 R5 sweep over every ratio, mode and order
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 2; l++)
          xfer(r, m, l, 8'((r * 37 + m * 11 + l * 5 + 8'h5A) & 8'hFF),
               8'(~((r * 37 + m * 11 + l * 5 + 8'h5A) & 8'hFF) ^ 8'h33));

    // R7 R12 collision mid-transfer
    bw(0, AC, 8'h50); bw(1, AC, 8'h40);
    bw(1, AD, 8'h96); s_ss = 0;
    repeat (4) @(negedge clk);
    bw(0, AD, 8'hA5);
    repeat (8) @(negedge clk);
    br(0, AS, d); chk("R12 busy during transfer", d, 8'h01);
    bw(0, AD, 8'h3C);
    br(0, AS, d); chk("R7 collision flagged", d, 8'h41);
    for (int n = 0; n < 200 && !m_irq; n++) @(negedge clk);
    repeat (4) @(negedge clk);
    br(1, AD, d); chk("R7 byte in flight intact", d, 8'hA5);
    br(0, AD, d); chk("R7 master received", d, 8'h96);
    br(0, AS, d); chk("R12 idle after transfer", d, 8'hC0);
    // R8 write-one-to-clear
    bw(0, AS, 8'h00); br(0, AS, d); chk("R8 zero write keeps flags", d, 8'hC0);
    bw(0, AS, 8'h80); br(0, AS, d); chk("R8 clear complete only", d, 8'h40);
    chk("R6 irq drops with flag", m_irq, 0);
    bw(0, AS, 8'h40); br(0, AS, d); chk("R8 clear collision", d, 8'h00);
    bw(1, AS, 8'hC0);

    // R10 deselected slave
    s_ss = 1;
    repeat (4) @(negedge clk);
    chk("R10 miso undriven", s_miso_oe, 0);
    bw(0, AD, 8'h12);
    for (int n = 0; n < 200 && !m_irq; n++) @(negedge clk);
    repeat (4) @(negedge clk);
    br(0, AD, d); chk("R10 master sees idle line", d, 8'hFF);
    chk("R10 slave no completion", s_irq, 0);
    br(1, AD, d); chk("R10 slave buffer unchanged", d, 8'hA5);
    bw(0, AS, 8'hC0);

    // R11 select conflict
    bw(0, AC, 8'hD0);
    m_ss = 0; repeat (5) @(negedge clk);
    br(0, AC, d); chk("R11 ignored select keeps master", d, 8'hD0);
    bw(0, AC, 8'h50);
    repeat (5) @(negedge clk);
    br(0, AC, d); chk("R11 conflict clears master", d, 8'h40);
    chk("R11 clock released", m_sck_oe, 0);
    chk("R9 pin_en when enabled", m_pen, 1);
    m_ss = 1;

    // R9 disabled block
    bw(0, AC, 8'h10);
    chk("R9 pin_en low", m_pen, 0);
    chk("R9 enables low", {m_sck_oe, m_mosi_oe, m_miso_oe}, 0);
    bw(0, AD, 8'h77);
    repeat (300) @(negedge clk);
    chk("R9 no completion", m_irq, 0);
    br(0, AS, d); chk("R9 not busy", d, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule